// File: doc/BRIEF.md
# Serial-In Parallel-Out Register with Output Latch

This block turns a serial bit stream into a parallel word in two stages. A chain of shift stages takes one bit from the serial input on every rising edge of a shift clock. A separate storage register takes a snapshot of the whole chain on every rising edge of a second clock, the latch clock. The parallel outputs show only the storage register, so the shift chain can be refilled while the outputs stay steady. An active-low enable can switch the parallel outputs to high impedance.

An active-low asynchronous clear empties the shift chain and leaves the storage register alone. The last shift stage is brought out directly as a cascade output. It feeds the serial input of a following instance, so several instances act as one longer register and keep their displayed words fixed until a common latch edge. The word width is a parameter.

Top module: `sipo_latch_reg`

## Requirements
- R1: On a rising edge of shift_clk_i with rst_ni high, stage 0 takes ser_i and each stage k > 0 takes the old value of stage k-1. The first bit shifted in reaches the highest stage (par_o[W-1]) after W edges, and the newest bit sits in stage 0 (par_o[0]).
- R2: While rst_ni is low, every shift stage is 0 at once, without any clock edge, and shift_clk_i edges have no effect.
- R3: rst_ni has no effect on the storage register: par_o keeps its value through a clear and changes only at the next latch edge.
- R4: On a rising edge of latch_clk_i, bit k of the storage register takes shift stage k for every k. At all other times the storage register holds its value, including across shift edges.
- R5: When oe_ni is 1, all bits of par_o are high impedance. When oe_ni is 0, par_o drives the storage register. oe_ni does not change the stored word.
- R6: cascade_o always equals the highest shift stage. It does not depend on the storage register or on oe_ni, and it changes on a shift edge without any latch edge.
- R7: When shift_clk_i and latch_clk_i rise together, the storage register takes the shift contents from before that edge, so it runs one shift behind the chain.
- R8: With cascade_o of one instance wired to ser_i of a second instance, and both sharing clocks and clear, the pair acts as a 2W-bit register. The second instance's par_o[W-1] holds the first of the last 2W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk_i | input | 1 | Shift clock, rising edge active |
| latch_clk_i | input | 1 | Storage register clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear of the shift stages, active low |
| ser_i | input | 1 | Serial data input |
| oe_ni | input | 1 | Parallel output enable, active low |
| par_o | output | W | Parallel outputs from the storage register, high impedance when disabled |
| cascade_o | output | 1 | Highest shift stage, for chaining |

## Verification
The bench sweeps every 8-bit value through a chain of two instances. It checks the bit order, so a reversed chain shows up as mirrored words. It checks that the outputs hold between latch edges, so a storage register that follows the shift chain shows up too. It applies a clear in the middle of a shift sequence and pulses the shift clock while the clear is low. A clear that also reset the storage register would drop the displayed word early, and a synchronous or non-overriding clear would let ones leak in. With the latch clock tied to the shift clock, a design that latched the post-shift value would run level with the chain instead of one behind. The outputs are read through pull-ups while disabled, so an enable that gates the data to zero, or one that corrupts the stored word, is caught. The cascade output is checked with the outputs disabled.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned SIPO_W_DEF = 8;
  localparam int unsigned SIPO_W_MIN = 2;
endpackage

// File: rtl/sipo_shift.sv
module sipo_shift #(
  parameter int unsigned W = sipo_pkg::SIPO_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic         pv_q;

  for (genvar k = 0; k < W; k++) begin : g_stage
    logic d;
    if (k == 0) begin : g_head
      assign d = ser_i;
    end else begin : g_body
      assign d = q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[k] <= 1'b0;
      else         q[k] <= d;
    end
  end

  // low from a clear until the first shift edge after it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv_q <= 1'b0;
    else         pv_q <= 1'b1;
  end

  assign q_o = q;

  assert_shift_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q |-> (q == {$past(q[W-2:0]), $past(ser_i)}));

  assert_clear_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pv_q |-> (q == '0));
endmodule

// File: rtl/sipo_store.sv
module sipo_store #(
  parameter int unsigned W = sipo_pkg::SIPO_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic         seen_q;

  // no reset on the word: the clear acts only on the shift chain
  always_ff @(posedge clk_i) q <= d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign q_o = q;

  assert_latch_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (q_o == $past(d_i)));
endmodule

// File: rtl/sipo_drive.sv
module sipo_drive #(
  parameter int unsigned W = sipo_pkg::SIPO_W_DEF
) (
  input  logic         oe_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] pad_o
);
  for (genvar k = 0; k < W; k++) begin : g_pad
    assign pad_o[k] = oe_ni ? 1'bz : d_i[k];
  end
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg #(
  parameter int unsigned W = sipo_pkg::SIPO_W_DEF
) (
  input  logic         shift_clk_i,
  input  logic         latch_clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  input  logic         oe_ni,
  output logic [W-1:0] par_o,
  output logic         cascade_o
);
  logic [W-1:0] shift_q;
  logic [W-1:0] store_q;
  logic         pv_q;

  if (W < sipo_pkg::SIPO_W_MIN) begin : g_bad_w
    initial $error("sipo_latch_reg: W below minimum");
  end

  sipo_shift #(.W(W)) u_shift (
    .clk_i (shift_clk_i),
    .rst_ni(rst_ni),
    .ser_i (ser_i),
    .q_o   (shift_q)
  );

  sipo_store #(.W(W)) u_store (
    .clk_i (latch_clk_i),
    .rst_ni(rst_ni),
    .d_i   (shift_q),
    .q_o   (store_q)
  );

  sipo_drive #(.W(W)) u_drive (
    .oe_ni(oe_ni),
    .d_i  (store_q),
    .pad_o(par_o)
  );

  // tap ahead of the storage register
  assign cascade_o = shift_q[W-1];

  always_ff @(posedge shift_clk_i or negedge rst_ni) begin
    if (!rst_ni) pv_q <= 1'b0;
    else         pv_q <= 1'b1;
  end

  assert_cascade_tap_R6: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    pv_q |-> (cascade_o == $past(shift_q[W-2])));
endmodule

// File: tb/sipo_latch_reg_test.sv
module sipo_latch_reg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic sclk_r = 1'b0, lclk_r = 1'b0, tie = 1'b0;
  logic rst_n = 1'b1, ser = 1'b0, oe_n = 1'b0;
  wire  latch_clk = tie ? sclk_r : lclk_r;
  wire  [W-1:0] par_a;
  wire  [W-1:0] par_b;
  wire  casc_a, casc_b;

  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup (par_a[i]);
  end

  sipo_latch_reg #(.W(W)) uut (
    .shift_clk_i(sclk_r), .latch_clk_i(latch_clk), .rst_ni(rst_n),
    .ser_i(ser), .oe_ni(oe_n), .par_o(par_a), .cascade_o(casc_a));

  sipo_latch_reg #(.W(W)) uut_b (
    .shift_clk_i(sclk_r), .latch_clk_i(latch_clk), .rst_ni(rst_n),
    .ser_i(casc_a), .oe_ni(1'b0), .par_o(par_b), .cascade_o(casc_b));

  int checks = 0, errors = 0;
  logic [2*W-1:0] ref_q = '0;
  logic [W-1:0]   ref_a = '0, ref_b = '0;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(logic b);
    ser = b; #1;
    sclk_r = 1'b1; #2.5;
    sclk_r = 1'b0; #1.5;
    ref_q = {ref_q[2*W-2:0], b};
  endtask

  task automatic latch_pulse();
    lclk_r = 1'b1; #2.5;
    lclk_r = 1'b0; #1.5;
    ref_a = ref_q[W-1:0];
    ref_b = ref_q[2*W-1:W];
  endtask

  task automatic tied_bit(logic b);
    logic [2*W-1:0] old;
    old = ref_q;
    ser = b; #1;
    sclk_r = 1'b1; #2.5;
    sclk_r = 1'b0; #1.5;
    ref_q = {ref_q[2*W-2:0], b};
    ref_a = old[W-1:0];
    ref_b = old[2*W-1:W];
  endtask

  task automatic clear_pulse();
    rst_n = 1'b0; #2;
    rst_n = 1'b1; #2;
    ref_q = '0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    #3;
    clear_pulse();
    latch_pulse();
    check("R2 reset par_a", 16'(par_a), 16'h00);
    check("R2 reset par_b", 16'(par_b), 16'h00);
    check("R6 reset cascade", 16'(casc_a), 16'h0);

    // R1 R4 R8: every 8-bit value, first bit lands on the top output
    prev = '0;
    for (int v = 0; v < 256; v++) begin
      for (int k = W - 1; k >= 0; k--) shift_bit(v[k]);
      check("R4 hold before latch", 16'(par_a), 16'(prev));
      check("R6 cascade is first bit", 16'(casc_a), 16'(v[W-1]));
      latch_pulse();
      check("R1 word order", 16'(par_a), 16'(v));
      check("R8 chained word", 16'(par_b), 16'(prev));
      prev = W'(v);
    end

    // R2 R3: clear in the middle of a shift sequence
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b1);
    latch_pulse();
    check("R1 partial word", 16'(par_a), 16'(ref_a));
    prev = par_a;
    shift_bit(1'b1);
    clear_pulse();
    check("R3 storage kept over clear", 16'(par_a), 16'(prev));
    check("R2 cascade cleared", 16'(casc_a), 16'h0);
    latch_pulse();
    check("R2 chain cleared", 16'(par_a), 16'h00);
    check("R2 chain b cleared", 16'(par_b), 16'h00);
    // R2: shift edges while clear held low
    rst_n = 1'b0; #1;
    shift_bit(1'b1); shift_bit(1'b1);
    ref_q = '0;
    rst_n = 1'b1; #2;
    latch_pulse();
    check("R2 clear overrides shift", 16'(par_a), 16'h00);
    shift_bit(1'b1);
    latch_pulse();
    check("R2 shift resumes after clear", 16'(par_a), 16'h01);

    // R6: cascade follows each shift, no latch
    for (int k = 0; k < 10; k++) begin
      shift_bit(k[0] ^ k[2]);
      check("R6 cascade per shift", 16'(casc_a), 16'(ref_q[W-1]));
    end

    // R5: disabled outputs read through pull-ups
    clear_pulse();
    latch_pulse();
    oe_n = 1'b1; #1;
    check("R5 disabled zero word", 16'(par_a), 16'hFF);
    for (int k = W - 1; k >= 0; k--) shift_bit(8'hA5 >> k);
    check("R6 cascade while disabled", 16'(casc_a), 16'h1);
    latch_pulse();
    check("R5 disabled A5 word", 16'(par_a), 16'hFF);
    oe_n = 1'b0; #1;
    check("R5 enabled shows stored", 16'(par_a), 16'hA5);
    oe_n = 1'b1; #1;
    oe_n = 1'b0; #1;
    check("R5 toggle keeps word", 16'(par_a), 16'hA5);

    // R7: tied clocks, storage one shift behind
    tie = 1'b1;
    for (int k = W - 1; k >= 0; k--) begin
      tied_bit(8'h3C >> k);
      check("R7 tied one behind", 16'(par_a), 16'(ref_a));
      check("R7 tied chain b", 16'(par_b), 16'(ref_b));
    end
    tie = 1'b0;
    latch_pulse();
    check("R7 catch up", 16'(par_a), 16'h3C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule